// File: doc/BRIEF.md
# Parallel Trivium Keystream Random Generator

This block is a pseudo-random bit source that runs the Trivium stream-cipher state update. It delivers the keystream as words of W bits, where W is a synthesis parameter. Its seed is an 80-bit key and an 80-bit IV. The seed is taken from the input ports on synchronous reset, and again whenever the reseed strobe is raised.

After any load, the generator first runs a warm-up phase of 1152 rounds, which takes 1152/W clocks. No word is offered during this phase. After the warm-up, the current word stays on the output, marked valid, and it does not change until the consumer raises the advance input. Each clock with advance high moves the state forward by W rounds and presents the next W keystream bits. Only registers and gate-level logic are used.

Top module: `kstream_rng`

## Requirements
- R1: On a clock edge with `rst` or `reseed_i` high, the state loads as follows, with state bits numbered s1..s288. Key bit `key_i[j]` goes to s(j+1) and IV bit `iv_i[j]` goes to s(94+j), for j = 0..79. Bits s286, s287 and s288 are set to 1, and every other bit is cleared.
- R2: One round computes a = s66^s93, b = s162^s177 and c = s243^s288, and its keystream bit is a^b^c. Three feedback bits are formed: a^(s91&s92)^s171 enters s94, b^(s175&s176)^s264 enters s178, and c^(s286&s287)^s69 enters s1. Each of the three registers s1..s93, s94..s177 and s178..s288 shifts by one position toward its higher index.
- R3: W may be any power of two from 1 to 64. Bit i of `word_o` is the keystream bit of round i of the current word, so the earliest round sits in bit 0.
- R4: `valid_o` is low during reset. After the loading edge, `valid_o` stays low for exactly 1152/W clock edges and is high after the (1152/W)-th edge. The first valid word is made of keystream bits 0..W-1, counted from round 1152.
- R5: During warm-up the state advances W rounds on every clock, whatever the level of `adv_i`. Holding `adv_i` high during warm-up does not change the first valid word.
- R6: Each clock edge with `valid_o` and `adv_i` both high moves the state forward by W rounds. `word_o` then carries the next W keystream bits in sequence.
- R7: While `valid_o` is high and `adv_i` is low, `word_o` and `valid_o` keep their values.
- R8: A reseed at any time, including during warm-up, reloads the seed per R1. It drops `valid_o` on the following cycle, restarts the full 1152/W-cycle warm-up, and restarts the keystream from the new seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the seed |
| reseed_i | input | 1 | Reseed strobe; loads the seed and restarts warm-up |
| key_i | input | 80 | Key half of the seed |
| iv_i | input | 80 | IV half of the seed |
| adv_i | input | 1 | Consume the current word and advance W rounds |
| word_o | output | W | Current random word, earliest round in bit 0 |
| valid_o | output | 1 | Warm-up complete, word_o is valid |

## Verification
The case that is hardest to reach from the ports is a reseed that arrives in the middle of a warm-up that is already running. A design that only clears the counter, or only reloads the state, can still produce plausible-looking words afterwards. The stimulus first reseeds after valid data has been flowing. Ten clocks into the new warm-up, it reseeds again with a third seed. It then measures the length of the blank period for W = 1, 32 and 64, and compares the words that follow against a bit-serial software model of the third seed.

// File: rtl/kstream_pkg.sv
package kstream_pkg;
    localparam int KEY_W       = 80;
    localparam int IV_W        = 80;
    localparam int ST_W        = 288;
    localparam int WARM_ROUNDS = 1152;
    localparam int IV_BASE     = 93;   // zero-based position of s94
    localparam int ONES_BASE   = 285;  // zero-based position of s286

    // Zero-based vector: element k-1 holds state bit s_k
    typedef logic [ST_W-1:0] kstate_t;

    function automatic kstate_t seed_state(input logic [KEY_W-1:0] k,
                                           input logic [IV_W-1:0]  v);
        kstate_t s;
        s = '0;
        s[KEY_W-1:0]               = k;
        s[IV_BASE+IV_W-1:IV_BASE]  = v;
        s[ST_W-1:ONES_BASE]        = 3'b111;
        return s;
    endfunction
endpackage

// File: rtl/kstream_rounds.sv
module kstream_rounds
    import kstream_pkg::*;
#(
    parameter int W = 32
) (
    input  kstate_t        st_i,
    output kstate_t        st_o,
    output logic [W-1:0]   z_o
);
    // chain[i] is the state before round i of this cycle
    kstate_t chain [0:W];

    assign chain[0] = st_i;

    for (genvar i = 0; i < W; i++) begin : g_round
        logic ta, tb, tc;
        logic fa, fb, fc;
        kstate_t cur;

        assign cur = chain[i];
        assign ta  = cur[65]  ^ cur[92];
        assign tb  = cur[161] ^ cur[176];
        assign tc  = cur[242] ^ cur[287];
        assign z_o[i] = ta ^ tb ^ tc;

        assign fa = ta ^ (cur[90]  & cur[91])  ^ cur[170];
        assign fb = tb ^ (cur[174] & cur[175]) ^ cur[263];
        assign fc = tc ^ (cur[285] & cur[286]) ^ cur[68];

        assign chain[i+1] = {cur[286:177], fb,
                             cur[175:93],  fa,
                             cur[91:0],    fc};
    end

    assign st_o = chain[W];
endmodule

// File: rtl/kstream_warmup.sv
module kstream_warmup #(
    parameter int CYC = 36
) (
    input  logic clk,
    input  logic rst,
    input  logic reseed_i,
    output logic warming_o,
    output logic ready_o
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (rst || reseed_i) begin
            ctl_d.cnt = '0;
        end else if (ctl_q.cnt != LAST) begin
            ctl_d.cnt = ctl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign ready_o   = (ctl_q.cnt == LAST);
    assign warming_o = !ready_o;

    // R4: the count never runs past the warm-up length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        ctl_q.cnt <= LAST);

    // R4: readiness appears only after the last warm-up step
    a_r4_ready_after_count: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> ($past(ctl_q.cnt) == LAST - 1'b1));
endmodule

// File: rtl/kstream_rng.sv
module kstream_rng
    import kstream_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reseed_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [IV_W-1:0]  iv_i,
    input  logic             adv_i,
    output logic [W-1:0]     word_o,
    output logic             valid_o
);
    localparam int WARM_CYC = WARM_ROUNDS / W;

    initial begin
        assert (W >= 1 && W <= 64 && (W & (W - 1)) == 0)
            else $error("kstream_rng: W must be a power of two in 1..64");
    end

    typedef struct packed {
        kstate_t st;
    } dp_t;

    dp_t     dp_d, dp_q;
    kstate_t st_next;
    logic    warming;
    logic    load;
    logic    step;

    kstream_rounds #(.W(W)) u_rounds (
        .st_i (dp_q.st),
        .st_o (st_next),
        .z_o  (word_o)
    );

    kstream_warmup #(.CYC(WARM_CYC)) u_warmup (
        .clk       (clk),
        .rst       (rst),
        .reseed_i  (reseed_i),
        .warming_o (warming),
        .ready_o   (valid_o)
    );

    assign load = rst || reseed_i;
    assign step = warming || (valid_o && adv_i);

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.st = seed_state(key_i, iv_i);
        end else if (step) begin
            dp_d.st = st_next;
        end
    end

    always_ff @(posedge clk) begin
        dp_q <= dp_d;
    end

    // R8: a reseed blanks the output on the next cycle
    a_r8_reseed_blanks: assert property (@(posedge clk) disable iff (rst)
        reseed_i |=> !valid_o);

    // R8: valid only drops because of a reseed
    a_r8_drop_needs_reseed: assert property (@(posedge clk) disable iff (rst)
        $fell(valid_o) |-> $past(reseed_i));

    // R7: an unconsumed word holds
    a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !adv_i && !reseed_i) |=> (valid_o && $stable(word_o)));
endmodule

// File: tb/kstream_rng_bench.sv
module kstream_rng_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        reseed;
    logic [79:0] key, iv;
    logic        adv;
    logic [31:0] w32;
    logic [0:0]  w1;
    logic [63:0] w64;
    logic        v32, v1, v64;

    int checks = 0;
    int fails  = 0;
    bit ks [0:4095];
    logic [31:0] exp_q [$];
    int sb_ptr = 0;
    int i1 = 0;
    int i64 = 0;
    bit done = 0;

    always #4 clk = ~clk;

    kstream_rng #(.W(32)) u_kstream_rng (
        .clk(clk), .rst(rst), .reseed_i(reseed), .key_i(key), .iv_i(iv),
        .adv_i(adv), .word_o(w32), .valid_o(v32));
    kstream_rng #(.W(1)) u_kstream_rng_w1 (
        .clk(clk), .rst(rst), .reseed_i(reseed), .key_i(key), .iv_i(iv),
        .adv_i(adv), .word_o(w1), .valid_o(v1));
    kstream_rng #(.W(64)) u_kstream_rng_w64 (
        .clk(clk), .rst(rst), .reseed_i(reseed), .key_i(key), .iv_i(iv),
        .adv_i(adv), .word_o(w64), .valid_o(v64));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bit-serial model written from R1/R2, 1-based state indices
    task automatic model_run(input logic [79:0] k, input logic [79:0] v);
        bit s [1:288];
        bit a, b, c, z;
        for (int i = 1; i <= 288; i++) s[i] = 1'b0;
        for (int j = 0; j < 80; j++) begin
            s[j+1]  = k[j];
            s[j+94] = v[j];
        end
        s[286] = 1'b1; s[287] = 1'b1; s[288] = 1'b1;
        for (int r = 0; r < 1152 + 4096; r++) begin
            a = s[66] ^ s[93];
            b = s[162] ^ s[177];
            c = s[243] ^ s[288];
            z = a ^ b ^ c;
            a = a ^ (s[91] & s[92]) ^ s[171];
            b = b ^ (s[175] & s[176]) ^ s[264];
            c = c ^ (s[286] & s[287]) ^ s[69];
            for (int i = 93; i >= 2; i--) s[i] = s[i-1];
            s[1] = c;
            for (int i = 177; i >= 95; i--) s[i] = s[i-1];
            s[94] = a;
            for (int i = 288; i >= 179; i--) s[i] = s[i-1];
            s[178] = b;
            if (r >= 1152) ks[r-1152] = z;
        end
    endtask

    function automatic logic [63:0] bits_at(input int start, input int width);
        logic [63:0] r = '0;
        for (int i = 0; i < width; i++) r[i] = ks[start+i];
        return r;
    endfunction

    // Driver side of the scoreboard (R3, R6): expected W=32 words
    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(bits_at(sb_ptr, 32)[31:0]);
            sb_ptr += 32;
        end
    endtask

    task automatic new_seed(input logic [79:0] k, input logic [79:0] v);
        exp_q.delete();
        model_run(k, v);
        sb_ptr = 0; i1 = 0; i64 = 0;
        push_words(40);
    endtask

    // Monitor: compares every consumed word
    always @(negedge clk) begin
        if (!rst && !done && adv) begin
            if (v32) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "scoreboard underrun", 64'(w32), 64'd0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(w32 == e, "R6", "W=32 word", 64'(w32), 64'(e));
                end
            end
            if (v1) begin
                chk(w1[0] == ks[i1], "R3", "W=1 bit", 64'(w1), 64'(ks[i1]));
                i1++;
            end
            if (v64) begin
                chk(w64 == bits_at(i64 * 64, 64), "R3", "W=64 word",
                    w64, bits_at(i64 * 64, 64));
                i64++;
            end
        end
    end

    // R4/R5: measure warm-up length with adv high for the first few cycles
    task automatic measure(input string req);
        int f1 = -1, f32 = -1, f64 = -1;
        for (int n = 0; n < 1200; n++) begin
            @(negedge clk);
            if (v1  && f1  < 0) f1  = n;
            if (v32 && f32 < 0) f32 = n;
            if (v64 && f64 < 0) f64 = n;
            @(posedge clk); #1;
            adv = (n < 8);
        end
        chk(f32 == 36,   req, "W=32 warm-up cycles", 64'(f32), 64'd36);
        chk(f64 == 18,   req, "W=64 warm-up cycles", 64'(f64), 64'd18);
        chk(f1  == 1152, req, "W=1 warm-up cycles",  64'(f1),  64'd1152);
    endtask

    task automatic consume(input int n);
        @(posedge clk); #1 adv = 1'b1;
        repeat (n) @(posedge clk);
        #1 adv = 1'b0;
    endtask

    task automatic do_reseed(input logic [79:0] k, input logic [79:0] v);
        @(posedge clk); #1;
        new_seed(k, v);
        key = k; iv = v; reseed = 1'b1;
        @(posedge clk); #1 reseed = 1'b0;
    endtask

    initial begin
        logic [31:0] h32;
        logic [63:0] h64;
        logic [0:0]  h1;
        rst = 1'b1; reseed = 1'b0; adv = 1'b1;
        key = 80'h0123_4567_89ab_cdef_1357;
        iv  = 80'hfedc_ba98_7654_3210_2468;
        new_seed(key, iv);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!v32 && !v1 && !v64, "R4", "valid low in reset",
            64'({v1, v32, v64}), 64'd0);
        @(posedge clk); #1 rst = 1'b0;
        measure("R5");          // adv high early in warm-up: R5, R4
        consume(20);            // R1 R2 R3 R6 via monitor
        chk(exp_q.size() == 20, "R6", "W=32 words consumed",
            64'(40 - exp_q.size()), 64'd20);

        // R7: hold with adv low
        @(negedge clk);
        h32 = w32; h64 = w64; h1 = w1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(w32 == h32 && v32, "R7", "W=32 hold", 64'(w32), 64'(h32));
        chk(w64 == h64 && v64, "R7", "W=64 hold", w64, h64);
        chk(w1 == h1 && v1,    "R7", "W=1 hold",  64'(w1), 64'(h1));
        consume(5);

        // R8: reseed after valid data
        do_reseed(80'h0, 80'h0);
        @(negedge clk);
        chk(!v32 && !v1 && !v64, "R8", "valid drops after reseed",
            64'({v1, v32, v64}), 64'd0);
        repeat (10) @(posedge clk);
        // R8: second reseed in the middle of warm-up
        do_reseed(80'hdead_beef_0bad_cafe_f00d, 80'h1111_2222_3333_4444_5555);
        measure("R8");
        consume(12);
        chk(exp_q.size() == 28, "R8", "W=32 words after mid-warm-up reseed",
            64'(40 - exp_q.size()), 64'd12);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule